// File: doc/BRIEF.md
# Linked-Descriptor Rectangular Copy Engine

This block is a single DMA channel that moves a rectangle of 32-bit words from one memory region to another. Software places one or more four-word descriptors in memory, writes the address of the first into the head register and sets the start bit in the command register. The channel reads the descriptor and copies the data row by row. After each row it moves the source and destination row starts forward by their own strides. It then follows the chain of descriptors until it reaches a node tagged as the last one.

Each descriptor gives a source address, a destination address, the two strides, a row width and a total byte count. When the row width equals both strides, the copy is one contiguous block. Software polls the end flag in the command register to learn that the chain has finished. Writing the soft-reset bit abandons a transfer at once.

The memory port handles one word per accepted request. A grant input lets the memory hold off a request for as many cycles as it needs.

Top module: `dma2d_copy`

## Requirements
- R1: After reset the busy bit and the end flag read 0, no memory request is raised, and the head register reads 0.
- R2: The head register is at register select 0. It keeps written bits 31..2, and bits 1..0 always read 0. It can be written while a transfer runs without disturbing that transfer.
- R3: The command register is at register select 1. A write with bit 0 set and bit 1 clear starts a transfer if the channel is idle, and clears the end flag (bit 2). While the transfer runs, bit 0 reads back 1. A start written while busy is ignored.
- R4: Each descriptor is fetched as four word reads, at the node address plus 0, 4, 8 and 12, in that order. The words hold, in order:
  - Word 0: the source address.
  - Word 1: the destination address.
  - Word 2: the source stride in bits 29..16 and the destination stride in bits 13..0. Bits 31..30 and 15..14 are ignored.
  - Word 3: the last-node tag in bit 31, the row width in bytes in bits 30..16, and the total byte count in bits 15..0.
- R5: Each data word is read from the source and then written, unchanged, to the destination. Within a row, both addresses step by 4.
- R6: After each row of row-width bytes, the source row start advances by the source stride and the destination row start advances by the destination stride.
- R7: A node ends when the number of bytes moved reaches its total count. A node with a total of 0 moves nothing.
- R8: When a node ends with its tag clear, the next descriptor is fetched from the node address plus 16. When a node ends with its tag set, the end flag is set and the busy bit drops.
- R9: When the row width equals both strides, the node copies the total count as one contiguous block.
- R10: Addresses, strides, row width and total count are taken at 4-byte granularity: their two low bits are ignored.
- R11: A command write with bit 1 set is a soft reset:
  - No memory request is raised in that cycle or afterwards.
  - The busy bit and the end flag read 0 in the following cycle.
  - A start bit in the same write is ignored.
- R12: While the grant input is low, a raised request keeps its address and its write enable unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 = head address, 1 = command/status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register (combinational) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Byte address, always word aligned |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid in the cycle the request is granted |
| memGnt | input | 1 | Grant: the request completes in this cycle |

## Verification
Two functions can fall in the same cycle.

A soft reset can arrive in a cycle where the channel has a granted data write on the port. It can also arrive in the same write as a start bit. The bench provokes the first by issuing the reset mid-copy, with grant stalls active. It provokes the second by writing both bits at once. It then judges the result from the port: no request may appear in the reset cycle or later, the destination word count stays frozen, and busy and the end flag both read 0.

Start-while-busy is provoked together with a head rewrite during a stalled copy. The bench expects exactly one chain to complete, with the original data.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int WORD_BYTES = 4;
  localparam int SRC_STRIDE_MSB = 29;
  localparam int SRC_STRIDE_LSB = 16;
  localparam int DST_STRIDE_MSB = 13;
  localparam int ROW_MSB = 30;
  localparam int ROW_LSB = 16;
  localparam int TOTAL_MSB = 15;
  localparam int TAG_BIT = 31;
  localparam int DESC_WORDS = 4;
  localparam int DESC_IDX_W = $clog2(DESC_WORDS);
  localparam int ROW_WORDS_W = ROW_MSB - ROW_LSB + 1 - 2;
  localparam int TOTAL_WORDS_W = TOTAL_MSB + 1 - 2;
  localparam int STRIDE_WORDS_W = DST_STRIDE_MSB + 1 - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_CHECK, ST_READ, ST_WRITE
  } state_e;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addrSel_e;

  typedef struct packed {
    logic                  loadHead;
    logic                  captureDesc;
    logic [DESC_IDX_W-1:0] descIdx;
    logic                  nextDesc;
    logic                  startNode;
    logic                  captureData;
    logic                  stepWord;
    addrSel_e              addrSel;
  } strobes_t;
endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic       regSel,
  input  logic [1:0] cmdBits,
  input  logic       nodeDone,
  input  logic       lastTag,
  input  logic       memGnt,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       endFlag,
  output strobes_t   strb
);
  state_e state, nextState;
  logic [DESC_IDX_W-1:0] idx;
  logic swRst, startReq, startAcc, finish;

  assign swRst    = regWe && regSel && cmdBits[1];
  assign startReq = regWe && regSel && cmdBits[0] && !cmdBits[1];
  assign startAcc = startReq && (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strb         = '0;
    strb.addrSel = SEL_DESC;
    strb.descIdx = idx;
    memReq       = 1'b0;
    memWe        = 1'b0;
    finish       = 1'b0;
    nextState    = state;
    unique case (state)
      ST_IDLE: begin
        if (startAcc) begin
          strb.loadHead = 1'b1;
          nextState     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memGnt) begin
          strb.captureDesc = 1'b1;
          if (idx == DESC_IDX_W'(DESC_WORDS - 1)) nextState = ST_SETUP;
        end
      end
      ST_SETUP: begin
        strb.startNode = 1'b1;
        nextState      = ST_CHECK;
      end
      ST_CHECK: begin
        if (nodeDone) begin
          if (lastTag) begin
            finish    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strb.nextDesc = 1'b1;
            nextState     = ST_FETCH;
          end
        end else begin
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        memReq       = 1'b1;
        strb.addrSel = SEL_SRC;
        if (memGnt) begin
          strb.captureData = 1'b1;
          nextState        = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSel = SEL_DST;
        if (memGnt) begin
          strb.stepWord = 1'b1;
          nextState     = ST_CHECK;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    if (swRst) begin
      strb         = '0;
      strb.addrSel = SEL_DESC;
      memReq       = 1'b0;
      memWe        = 1'b0;
      finish       = 1'b0;
      nextState    = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idx <= '0;
    else if (swRst || strb.loadHead || strb.nextDesc) idx <= '0;
    else if (strb.captureDesc) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         endFlag <= 1'b0;
    else if (swRst)    endFlag <= 1'b0;
    else if (startAcc) endFlag <= 1'b0;
    else if (finish)   endFlag <= 1'b1;
  end

  // R11: soft reset leaves the channel idle with the end flag clear
  a_r11_soft_reset_quiets: assert property (@(posedge clk) disable iff (!rstN)
    swRst |=> (!busy && !endFlag));
  // R3: an accepted start runs with the end flag clear
  a_r3_start_clears_end: assert property (@(posedge clk) disable iff (!rstN)
    startAcc |=> (busy && !endFlag));
  // R8: end of chain raises the flag and leaves busy
  a_r8_finish_sets_end: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> (endFlag && !busy));
  // R8: the end flag is never seen while busy
  a_r8_end_means_idle: assert property (@(posedge clk) disable iff (!rstN)
    endFlag |-> !busy);
endmodule

// File: rtl/dma2d_datapath.sv
module dma2d_datapath
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                headWe,
  input  logic [ADDR_W-3:0]   headWdata,
  input  strobes_t            strb,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [ADDR_W-3:0]   headW,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                nodeDone,
  output logic                lastTag
);
  localparam int WA_W = ADDR_W - 2;

  logic [DATA_W-1:0] descWord [DESC_WORDS];
  logic [WA_W-1:0] descAddr, srcRow, dstRow, curAddr;
  logic [ROW_WORDS_W-1:0] col, rowWords;
  logic [ROW_WORDS_W:0] colNext;
  logic [TOTAL_WORDS_W-1:0] cnt, totWords;
  logic [STRIDE_WORDS_W-1:0] srcStrideW, dstStrideW;
  logic [WA_W-1:0] srcBaseW, dstBaseW;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       headW <= '0;
    else if (headWe) headW <= headWdata;
  end

  genvar k;
  generate
    for (k = 0; k < DESC_WORDS; k++) begin : g_desc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) descWord[k] <= '0;
        else if (strb.captureDesc && strb.descIdx == DESC_IDX_W'(k))
          descWord[k] <= memRdata;
      end
    end
  endgenerate

  assign srcBaseW   = descWord[0][ADDR_W-1:2];
  assign dstBaseW   = descWord[1][ADDR_W-1:2];
  assign srcStrideW = descWord[2][SRC_STRIDE_MSB:SRC_STRIDE_LSB+2];
  assign dstStrideW = descWord[2][DST_STRIDE_MSB:2];
  assign lastTag    = descWord[3][TAG_BIT];
  assign rowWords   = descWord[3][ROW_MSB:ROW_LSB+2];
  assign totWords   = descWord[3][TOTAL_MSB:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              descAddr <= '0;
    else if (strb.loadHead) descAddr <= headW;
    else if (strb.nextDesc) descAddr <= descAddr + WA_W'(DESC_WORDS);
  end

  assign colNext  = {1'b0, col} + 1'b1;
  assign nodeDone = (cnt >= totWords);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcRow <= '0;
      dstRow <= '0;
      col    <= '0;
      cnt    <= '0;
    end else if (strb.startNode) begin
      srcRow <= srcBaseW;
      dstRow <= dstBaseW;
      col    <= '0;
      cnt    <= '0;
    end else if (strb.stepWord) begin
      cnt <= cnt + 1'b1;
      if (colNext >= {1'b0, rowWords}) begin
        col    <= '0;
        srcRow <= srcRow + WA_W'(srcStrideW);
        dstRow <= dstRow + WA_W'(dstStrideW);
      end else begin
        col <= colNext[ROW_WORDS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dataReg <= '0;
    else if (strb.captureData) dataReg <= memRdata;
  end

  always_comb begin
    unique case (strb.addrSel)
      SEL_SRC: curAddr = srcRow + WA_W'(col);
      SEL_DST: curAddr = dstRow + WA_W'(col);
      default: curAddr = descAddr + WA_W'(strb.descIdx);
    endcase
  end

  assign memAddr  = {curAddr, 2'b00};
  assign memWdata = dataReg;

  // R7: no word is moved once the node total has been reached
  a_r7_count_below_total: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepWord |-> (cnt < totWords));
  // R6: the column stays inside the row width
  a_r6_col_in_row: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepWord |-> (col < rowWords || col == '0));
endmodule

// File: rtl/dma2d_copy.sv
module dma2d_copy
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memGnt
);
  strobes_t strb;
  logic busy, endFlag, nodeDone, lastTag;
  logic [ADDR_W-3:0] headW;

  dma2d_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .cmdBits(regWdata[1:0]), .nodeDone(nodeDone), .lastTag(lastTag),
    .memGnt(memGnt), .memReq(memReq), .memWe(memWe), .busy(busy),
    .endFlag(endFlag), .strb(strb)
  );

  dma2d_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .headWe(regWe && !regSel),
    .headWdata(regWdata[ADDR_W-1:2]), .strb(strb), .memRdata(memRdata),
    .headW(headW), .memAddr(memAddr), .memWdata(memWdata),
    .nodeDone(nodeDone), .lastTag(lastTag)
  );

  assign regRdata = regSel ? {{(DATA_W-3){1'b0}}, endFlag, 1'b0, busy}
                           : DATA_W'({headW, 2'b00});

  // R12: a stalled request holds its address and direction
  a_r12_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> ((regWe && regSel && regWdata[1]) ||
                             (memReq && $stable(memAddr) && $stable(memWe))));
endmodule

// File: tb/dma2d_copy_test.sv
module dma2d_copy_test;
  logic clk = 0, rstN = 0;
  logic regWe = 0, regSel = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata, memAddr, memWdata, memRdata;
  logic memReq, memWe;
  logic memGnt = 1;

  int checks = 0, errors = 0;
  int writeCount = 0, readLogN = 0, quietViol = 0, stallViol = 0;
  logic [31:0] readLog [8];
  logic [31:0] mem [1024];
  logic stallMode = 0, watchQuiet = 0, prevPend = 0;
  logic [31:0] prevAddr = 0;
  logic [7:0] lfsr = 8'h5B;

  always #10 clk = ~clk;

  dma2d_copy uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memGnt(memGnt)
  );

  assign memRdata = mem[memAddr[11:2]];

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memGnt <= stallMode ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    if (prevPend && (!memReq || memAddr != prevAddr)) stallViol++;
    prevPend = memReq && !memGnt;
    prevAddr = memAddr;
    if (watchQuiet && memReq) quietViol++;
    if (memReq && memGnt) begin
      if (memWe) begin
        mem[memAddr[11:2]] <= memWdata;
        writeCount++;
      end else if (readLogN < 8) begin
        readLog[readLogN] = memAddr;
        readLogN++;
      end
    end
  end

  function automatic logic [31:0] initVal(input int byteAddr);
    return 32'h5E00_0000 | (byteAddr >> 2);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 0; regWdata = 0;
  endtask

  task automatic regRead(input logic sel, output logic [31:0] d);
    regSel = sel;
    #1;
    d = regRdata;
  endtask

  task automatic putDesc(input int at, input logic [31:0] w0, w1, w2, w3);
    mem[at >> 2] = w0;
    mem[(at >> 2) + 1] = w1;
    mem[(at >> 2) + 2] = w2;
    mem[(at >> 2) + 3] = w3;
  endtask

  task automatic waitEnd(input string req);
    logic [31:0] st;
    bit done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk);
      regRead(1, st);
      if (st[2]) done = 1;
    end
    check(done && !st[0], req, st, 32'h4);
  endtask

  task automatic runChain(input int head);
    regWrite(0, head);
    readLogN = 0;
    regWrite(1, 32'h1);
  endtask

  task automatic testReset;
    logic [31:0] v;
    regRead(1, v);
    check(v == 0, "R1 status", v, 0);
    regRead(0, v);
    check(v == 0, "R1 head", v, 0);
    check(memReq == 0, "R1 memReq", memReq, 0);
  endtask

  task automatic testHead;
    logic [31:0] v;
    regWrite(0, 32'hFFFF_FFFF);
    regRead(0, v);
    check(v == 32'hFFFF_FFFC, "R2 head low bits", v, 32'hFFFF_FFFC);
    regWrite(0, 32'h0000_0123);
    regRead(0, v);
    check(v == 32'h0000_0120, "R2 head mask", v, 32'h120);
  endtask

  task automatic testContiguous;
    logic [31:0] v;
    int base = writeCount;
    putDesc(32'h100, 32'h200, 32'h400, (16 << 16) | 16, (1 << 31) | (16 << 16) | 32);
    runChain(32'h100);
    regRead(1, v);
    check(v[0] == 1 && v[2] == 0, "R3 busy after start", v, 1);
    waitEnd("R8 end of contiguous");
    for (int i = 0; i < 4; i++)
      check(readLog[i] == 32'h100 + 4*i, "R4 fetch order", readLog[i], 32'h100 + 4*i);
    check(readLog[4] == 32'h200 && readLog[5] == 32'h204, "R5 source step",
          readLog[5], 32'h204);
    for (int i = 0; i < 8; i++)
      check(mem[(32'h400 >> 2) + i] == initVal(32'h200 + 4*i), "R9 contiguous data",
            mem[(32'h400 >> 2) + i], initVal(32'h200 + 4*i));
    check(mem[32'h420 >> 2] == initVal(32'h420), "R7 no overrun",
          mem[32'h420 >> 2], initVal(32'h420));
    check(writeCount - base == 8, "R7 word count", writeCount - base, 8);
  endtask

  task automatic test2d;
    putDesc(32'h110, 32'h600, 32'h800, (32 << 16) | 12, (1 << 31) | (8 << 16) | 24);
    runChain(32'h110);
    waitEnd("R8 end of 2d");
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 2; c++) begin
        int d = 32'h800 + r*12 + c*4;
        check(mem[d >> 2] == initVal(32'h600 + r*32 + c*4), "R6 strided copy",
              mem[d >> 2], initVal(32'h600 + r*32 + c*4));
      end
    check(mem[32'h808 >> 2] == initVal(32'h808), "R6 gap untouched",
          mem[32'h808 >> 2], initVal(32'h808));
  endtask

  task automatic testChain;
    int base = writeCount;
    putDesc(32'h140, 32'h300, 32'h900, (8 << 16) | 8, (8 << 16) | 8);
    putDesc(32'h150, 32'h300, 32'hA00, (8 << 16) | 8, (8 << 16) | 0);
    putDesc(32'h160, 32'h310, 32'h940, (4 << 16) | 4, (1 << 31) | (4 << 16) | 12);
    runChain(32'h140);
    waitEnd("R8 end of chain");
    check(readLog[6] == 32'h150, "R8 next node +16", readLog[6], 32'h150);
    check(writeCount - base == 5, "R7 zero-total node moves nothing",
          writeCount - base, 5);
    check(mem[32'hA00 >> 2] == initVal(32'hA00), "R7 zero node dest",
          mem[32'hA00 >> 2], initVal(32'hA00));
    check(mem[32'h904 >> 2] == initVal(32'h304), "R8 first node data",
          mem[32'h904 >> 2], initVal(32'h304));
    check(mem[32'h948 >> 2] == initVal(32'h318), "R8 last node data",
          mem[32'h948 >> 2], initVal(32'h318));
  endtask

  task automatic testLowBits;
    putDesc(32'h180, 32'h203, 32'hB02,
            (3 << 30) | (19 << 16) | (3 << 14) | 19, (1 << 31) | (11 << 16) | 19);
    runChain(32'h180);
    waitEnd("R10 end");
    check(mem[32'hB00 >> 2] == initVal(32'h200), "R10 row0 word0",
          mem[32'hB00 >> 2], initVal(32'h200));
    check(mem[32'hB04 >> 2] == initVal(32'h204), "R10 row0 word1",
          mem[32'hB04 >> 2], initVal(32'h204));
    check(mem[32'hB10 >> 2] == initVal(32'h210), "R10 row1 word0",
          mem[32'hB10 >> 2], initVal(32'h210));
    check(mem[32'hB14 >> 2] == initVal(32'h214), "R4 reserved bits ignored",
          mem[32'hB14 >> 2], initVal(32'h214));
    check(mem[32'hB08 >> 2] == initVal(32'hB08), "R10 gap untouched",
          mem[32'hB08 >> 2], initVal(32'hB08));
  endtask

  task automatic testStartBusy;
    logic [31:0] v;
    int base = writeCount;
    stallMode = 1;
    putDesc(32'h1C0, 32'h220, 32'hC00, (32 << 16) | 32, (1 << 31) | (32 << 16) | 32);
    runChain(32'h1C0);
    repeat (6) @(negedge clk);
    regWrite(0, 32'h100);
    regWrite(1, 32'h1);
    waitEnd("R3 end with ignored start");
    check(writeCount - base == 8, "R3 start while busy ignored", writeCount - base, 8);
    for (int i = 0; i < 8; i++)
      check(mem[(32'hC00 >> 2) + i] == initVal(32'h220 + 4*i), "R12 stalled copy data",
            mem[(32'hC00 >> 2) + i], initVal(32'h220 + 4*i));
    regRead(0, v);
    check(v == 32'h100, "R2 head written while busy", v, 32'h100);
    regWrite(1, 32'h1);
    regRead(1, v);
    check(v[2] == 0 && v[0] == 1, "R3 start clears end", v, 1);
    waitEnd("R3 restart end");
    stallMode = 0;
  endtask

  task automatic testSoftReset;
    logic [31:0] v;
    int base, frozen;
    stallMode = 1;
    base = writeCount;
    putDesc(32'h1E0, 32'h240, 32'hD00, (64 << 16) | 64, (1 << 31) | (64 << 16) | 64);
    runChain(32'h1E0);
    for (int i = 0; i < 2000 && writeCount - base < 3; i++) @(negedge clk);
    regWe = 1; regSel = 1; regWdata = 32'h3; watchQuiet = 1;
    @(negedge clk);
    regWe = 0; regWdata = 0;
    frozen = writeCount;
    regRead(1, v);
    check(v == 0, "R11 busy and end clear", v, 0);
    repeat (40) @(negedge clk);
    watchQuiet = 0;
    check(quietViol == 0, "R11 no request after reset", quietViol, 0);
    check(writeCount == frozen, "R11 writes frozen", writeCount, frozen);
    check(mem[(32'hD00 >> 2) + 15] == initVal(32'hD3C), "R11 tail untouched",
          mem[(32'hD00 >> 2) + 15], initVal(32'hD3C));
    stallMode = 0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = initVal(i*4);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testHead();
    testContiguous();
    test2d();
    testChain();
    testLowBits();
    testStartBusy();
    testSoftReset();
    check(stallViol == 0, "R12 stalled request stable", stallViol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule